// File: doc/BRIEF.md
# Post-Update Integer Load Unit

This unit carries out integer loads whose memory address is the base register's value as it stands. The base register is then advanced by an offset. An offset is either a sign-extended displacement or an index register value. The unit takes one decoded operation at a time, with these inputs:

- the access size;
- whether the loaded value is sign-extended;
- whether the offset is the displacement or the index;
- the base, index and displacement values;
- the target and base register numbers.

For each valid operation the unit issues one read with a valid/ready handshake. It waits for the 64-bit response and picks the addressed bytes out of it. It then presents two register writebacks in the same cycle: the loaded target value and the updated base.

Some register-number pairings are illegal. For these the unit raises an invalid-form flag and does nothing else. The unit alters no status or condition state. Decode, the register file, caches, alignment faults and stores belong to other blocks.

Top module: `pu_load_unit`

## Requirements
- R1: The read request address equals `base_val` exactly as presented with the operation, with no offset added. The request is held, with a stable address, until `mem_req_ready` is seen high.
- R2: For the immediate form (`op_indexed`=0) with `op_size` other than 3, the updated base is `base_val` plus the 16-bit `disp` sign-extended to 64 bits.
- R3: For the immediate form with `op_size`=3 (doubleword), the offset is `disp[15:2]` followed by two zero bits, sign-extended, so `disp[1:0]` has no effect on the updated base.
- R4: For the indexed form (`op_indexed`=1), the updated base is `base_val + index_val`, and `disp` has no effect.
- R5: Size codes are 0=byte, 1=halfword, 2=word, 3=doubleword. The response is big-endian: byte k of the aligned doubleword (k = address bits [2:0]) is `mem_rsp_data[63-8k -: 8]`. A halfword or word uses the lanes starting at k with the low 1 or 2 address bits cleared. With `op_signed`=0, byte, halfword and word loads put the value in the low 8, 16 or 32 bits and clear all higher bits.
- R6: With `op_signed`=1, halfword and word loads sign-extend the loaded value to 64 bits. For byte and doubleword loads `op_signed` has no effect.
- R7: A doubleword load writes all 64 response bits to the target unchanged.
- R8: An operation with `ra_num`=0 or `ra_num`=`rt_num` is an invalid form. `form_invalid` is high for exactly the one cycle after acceptance. No request is issued, no writeback occurs, and `busy` stays low.
- R9: `rt_we` and `ra_we` rise together, for one cycle, in the cycle after the response is accepted. They come with `rt_wnum`=`rt_num` and `ra_wnum`=`ra_num` of the operation. No write happens at any other time.
- R10: `op_ready` is high only while the unit is idle. `busy` is high from the cycle after a valid operation is accepted through the writeback cycle, and low afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Operation present |
| op_ready | output | 1 | Unit idle and can take an operation |
| op_size | input | 2 | Access size code (0 byte, 1 half, 2 word, 3 double) |
| op_signed | input | 1 | Sign-extend the loaded value |
| op_indexed | input | 1 | Offset is `index_val` instead of `disp` |
| base_val | input | XLEN | Base register value |
| index_val | input | XLEN | Index register value |
| disp | input | DISP_W | Displacement field |
| rt_num | input | RNUM_W | Target register number |
| ra_num | input | RNUM_W | Base register number |
| mem_req_valid | output | 1 | Read request valid |
| mem_req_ready | input | 1 | Read request taken |
| mem_req_addr | output | XLEN | Read address |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | XLEN | Big-endian doubleword read data |
| busy | output | 1 | Operation in flight |
| rt_we | output | 1 | Target writeback enable |
| rt_wnum | output | RNUM_W | Target writeback register number |
| rt_wdata | output | XLEN | Target writeback value |
| ra_we | output | 1 | Base writeback enable |
| ra_wnum | output | RNUM_W | Base writeback register number |
| ra_wdata | output | XLEN | Updated base value |
| form_invalid | output | 1 | One-cycle invalid-form flag |

## Verification
The bench builds the unit with its defaults: a 64-bit register width, 5-bit register numbers and a 16-bit displacement. At these values every byte, halfword and word lane of one response word can be reached, as can the negative displacements whose low two bits the doubleword form drops. Register 0 and target/base collisions are reachable as well. The loaded values have their top bit set, so zero extension and sign extension give visibly different results. The request is stalled for several cycles to show that the address holds.

// File: rtl/pu_load_pkg.sv
package pu_load_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE  = 2'd0,
    SZ_HALF  = 2'd1,
    SZ_WORD  = 2'd2,
    SZ_DWORD = 2'd3
  } acc_size_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_WAIT = 2'd2,
    ST_WB   = 2'd3
  } unit_state_e;
endpackage

// File: rtl/pu_load_form_check.sv
module pu_load_form_check #(
  parameter int RNUM_W = 5
) (
  input  logic [RNUM_W-1:0] rt_num,
  input  logic [RNUM_W-1:0] ra_num,
  output logic              invalid
);
  always_comb begin
    invalid = (ra_num == '0) || (ra_num == rt_num);
  end
endmodule

// File: rtl/pu_load_base_update.sv
module pu_load_base_update #(
  parameter int XLEN   = 64,
  parameter int DISP_W = 16
) (
  input  logic [XLEN-1:0]   base_val,
  input  logic [XLEN-1:0]   index_val,
  input  logic [DISP_W-1:0] disp,
  input  logic              indexed,
  input  logic              is_dword,
  output logic [XLEN-1:0]   new_base
);
  localparam int EXT_W = XLEN - DISP_W;

  logic [XLEN-1:0] offset;

  always_comb begin
    if (indexed) begin
      offset = index_val;
    end else if (is_dword) begin
      // word-scaled field: low two displacement bits forced to zero
      offset = {{EXT_W{disp[DISP_W-1]}}, disp[DISP_W-1:2], 2'b00};
    end else begin
      offset = {{EXT_W{disp[DISP_W-1]}}, disp};
    end
    new_base = base_val + offset;
  end
endmodule

// File: rtl/pu_load_lane_extract.sv
module pu_load_lane_extract
  import pu_load_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [XLEN-1:0]           rsp_data,
  input  logic [$clog2(XLEN/8)-1:0] lane,
  input  acc_size_e                 size,
  input  logic                      sign_ext,
  output logic [XLEN-1:0]           value
);
  localparam int BYTES  = XLEN / 8;
  localparam int LANE_W = $clog2(BYTES);

  logic [LANE_W-1:0] lane_al;
  logic [XLEN-1:0]   shifted;

  always_comb begin
    unique case (size)
      SZ_BYTE: lane_al = lane;
      SZ_HALF: lane_al = lane & ~LANE_W'(1);
      SZ_WORD: lane_al = lane & ~LANE_W'(3);
      default: lane_al = '0;
    endcase
    // move the addressed lane group to the top of the word
    shifted = rsp_data << {lane_al, 3'b000};
    unique case (size)
      SZ_BYTE: value = {{(XLEN-8){1'b0}}, shifted[XLEN-1 -: 8]};
      SZ_HALF: value = {{(XLEN-16){sign_ext & shifted[XLEN-1]}}, shifted[XLEN-1 -: 16]};
      SZ_WORD: value = {{(XLEN-32){sign_ext & shifted[XLEN-1]}}, shifted[XLEN-1 -: 32]};
      default: value = rsp_data;
    endcase
  end
endmodule

// File: rtl/pu_load_unit.sv
module pu_load_unit
  import pu_load_pkg::*;
#(
  parameter int XLEN   = 64,
  parameter int RNUM_W = 5,
  parameter int DISP_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  output logic              op_ready,
  input  logic [1:0]        op_size,
  input  logic              op_signed,
  input  logic              op_indexed,
  input  logic [XLEN-1:0]   base_val,
  input  logic [XLEN-1:0]   index_val,
  input  logic [DISP_W-1:0] disp,
  input  logic [RNUM_W-1:0] rt_num,
  input  logic [RNUM_W-1:0] ra_num,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [XLEN-1:0]   mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [XLEN-1:0]   mem_rsp_data,
  output logic              busy,
  output logic              rt_we,
  output logic [RNUM_W-1:0] rt_wnum,
  output logic [XLEN-1:0]   rt_wdata,
  output logic              ra_we,
  output logic [RNUM_W-1:0] ra_wnum,
  output logic [XLEN-1:0]   ra_wdata,
  output logic              form_invalid
);
  localparam int LANE_W = $clog2(XLEN/8);

  unit_state_e       state_q, state_d;
  logic [XLEN-1:0]   addr_q, newbase_q, ldval_q;
  acc_size_e         size_q;
  logic              signed_q;
  logic [RNUM_W-1:0] rt_q, ra_q;
  logic              inval_q, inval_d;

  logic              bad_form;
  logic [XLEN-1:0]   new_base;
  logic [XLEN-1:0]   ld_value;
  logic              take_op, capture_en, rsp_en;

  pu_load_form_check #(.RNUM_W(RNUM_W)) form_i (
    .rt_num  (rt_num),
    .ra_num  (ra_num),
    .invalid (bad_form)
  );

  pu_load_base_update #(.XLEN(XLEN), .DISP_W(DISP_W)) upd_i (
    .base_val  (base_val),
    .index_val (index_val),
    .disp      (disp),
    .indexed   (op_indexed),
    .is_dword  (op_size == 2'd3),
    .new_base  (new_base)
  );

  pu_load_lane_extract #(.XLEN(XLEN)) ext_i (
    .rsp_data (mem_rsp_data),
    .lane     (addr_q[LANE_W-1:0]),
    .size     (size_q),
    .sign_ext (signed_q),
    .value    (ld_value)
  );

  // next-state logic
  always_comb begin
    take_op    = (state_q == ST_IDLE) && op_valid;
    capture_en = take_op && !bad_form;
    rsp_en     = (state_q == ST_WAIT) && mem_rsp_valid;
    inval_d    = take_op && bad_form;
    state_d    = state_q;
    unique case (state_q)
      ST_IDLE: if (capture_en)    state_d = ST_REQ;
      ST_REQ:  if (mem_req_ready) state_d = ST_WAIT;
      ST_WAIT: if (mem_rsp_valid) state_d = ST_WB;
      default:                    state_d = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      inval_q <= 1'b0;
    end else begin
      state_q <= state_d;
      inval_q <= inval_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q    <= '0;
      newbase_q <= '0;
      size_q    <= SZ_BYTE;
      signed_q  <= 1'b0;
      rt_q      <= '0;
      ra_q      <= '0;
    end else if (capture_en) begin
      addr_q    <= base_val;
      newbase_q <= new_base;
      size_q    <= acc_size_e'(op_size);
      signed_q  <= op_signed;
      rt_q      <= rt_num;
      ra_q      <= ra_num;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ldval_q <= '0;
    end else if (rsp_en) begin
      ldval_q <= ld_value;
    end
  end

  // outputs
  always_comb begin
    op_ready      = (state_q == ST_IDLE);
    busy          = (state_q != ST_IDLE);
    mem_req_valid = (state_q == ST_REQ);
    mem_req_addr  = addr_q;
    rt_we         = (state_q == ST_WB);
    ra_we         = (state_q == ST_WB);
    rt_wnum       = rt_q;
    ra_wnum       = ra_q;
    rt_wdata      = ldval_q;
    ra_wdata      = newbase_q;
    form_invalid  = inval_q;
  end
endmodule

// File: rtl/pu_load_checker.sv
module pu_load_checker #(
  parameter int XLEN   = 64,
  parameter int RNUM_W = 5
) (
  input logic            clk,
  input logic            rst_n,
  input logic            op_valid,
  input logic            op_ready,
  input logic            mem_req_valid,
  input logic            mem_req_ready,
  input logic [XLEN-1:0] mem_req_addr,
  input logic            mem_rsp_valid,
  input logic            busy,
  input logic            rt_we,
  input logic            ra_we,
  input logic            form_invalid
);
  assert_req_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

  assert_inval_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    form_invalid |-> !busy && !mem_req_valid && !rt_we && !ra_we);

  assert_inval_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
    form_invalid |-> $past(op_valid && op_ready));

  assert_wb_after_rsp_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rt_we |-> $past(mem_rsp_valid) && ra_we);

  assert_wb_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rt_we |=> !rt_we && !ra_we);

  assert_req_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> busy && !op_ready);
endmodule

bind pu_load_unit pu_load_checker #(.XLEN(XLEN), .RNUM_W(RNUM_W)) chk_i (
  .clk           (clk),
  .rst_n         (rst_n),
  .op_valid      (op_valid),
  .op_ready      (op_ready),
  .mem_req_valid (mem_req_valid),
  .mem_req_ready (mem_req_ready),
  .mem_req_addr  (mem_req_addr),
  .mem_rsp_valid (mem_rsp_valid),
  .busy          (busy),
  .rt_we         (rt_we),
  .ra_we         (ra_we),
  .form_invalid  (form_invalid)
);

// File: tb/pu_load_unit_tb_top.sv
module pu_load_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic        op_ready;
  logic [1:0]  op_size = '0;
  logic        op_signed = 1'b0;
  logic        op_indexed = 1'b0;
  logic [63:0] base_val = '0;
  logic [63:0] index_val = '0;
  logic [15:0] disp = '0;
  logic [4:0]  rt_num = '0;
  logic [4:0]  ra_num = '0;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b0;
  logic [63:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [63:0] mem_rsp_data = '0;
  logic        busy;
  logic        rt_we, ra_we, form_invalid;
  logic [4:0]  rt_wnum, ra_wnum;
  logic [63:0] rt_wdata, ra_wdata;

  int checks = 0;
  int errors = 0;

  localparam logic [63:0] PAT = 64'h0123_4567_89AB_CDEF;

  always #5 clk = ~clk;

  pu_load_unit dut_i (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_ready(op_ready),
    .op_size(op_size), .op_signed(op_signed), .op_indexed(op_indexed),
    .base_val(base_val), .index_val(index_val), .disp(disp),
    .rt_num(rt_num), .ra_num(ra_num), .mem_req_valid(mem_req_valid),
    .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data), .busy(busy),
    .rt_we(rt_we), .rt_wnum(rt_wnum), .rt_wdata(rt_wdata), .ra_we(ra_we),
    .ra_wnum(ra_wnum), .ra_wdata(ra_wdata), .form_invalid(form_invalid)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // independent reference: bytes counted from the top of the response
  function automatic logic [63:0] ref_load(input logic [1:0] sz, input logic sg,
                                           input logic [63:0] addr,
                                           input logic [63:0] mem);
    int n = 1 << sz;
    int k = int'(addr[2:0]) / n * n;
    logic [63:0] raw = mem >> (8 * (8 - k - n));
    logic [63:0] res;
    if (n == 8) return mem;
    res = raw & ((64'd1 << (8 * n)) - 1);
    if (sg && n > 1 && res[8*n-1]) res = res | ~((64'd1 << (8 * n)) - 1);
    return res;
  endfunction

  function automatic logic [63:0] ref_base(input logic [1:0] sz, input logic ix,
                                           input logic [63:0] b, input logic [63:0] x,
                                           input logic [15:0] d);
    logic [63:0] off = {{48{d[15]}}, d};
    if (ix) return b + x;
    if (sz == 2'd3) off = off & ~64'd3;
    return b + off;
  endfunction

  task automatic run_op(input string tag, input logic [1:0] sz, input logic sg,
                        input logic ix, input logic [63:0] b, input logic [63:0] x,
                        input logic [15:0] d, input logic [4:0] rt, input logic [4:0] ra,
                        input logic [63:0] mem, input int stall);
    @(negedge clk);
    check(op_ready == 1'b1, {tag, " R10 ready idle"}, 64'(op_ready), 64'd1);
    op_valid = 1'b1; op_size = sz; op_signed = sg; op_indexed = ix;
    base_val = b; index_val = x; disp = d; rt_num = rt; ra_num = ra;
    @(posedge clk);
    @(negedge clk);
    op_valid = 1'b0; base_val = ~b; disp = ~d;
    check(busy && !op_ready, {tag, " R10 busy after accept"}, 64'(busy), 64'd1);
    check(mem_req_valid == 1'b1, {tag, " R1 req valid"}, 64'(mem_req_valid), 64'd1);
    check(mem_req_addr == b, {tag, " R1 address"}, mem_req_addr, b);
    for (int i = 0; i < stall; i++) begin
      @(posedge clk);
      @(negedge clk);
      check(mem_req_valid && mem_req_addr == b, {tag, " R1 held under stall"},
            mem_req_addr, b);
    end
    mem_req_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    mem_req_ready = 1'b0;
    check(!mem_req_valid && !rt_we, {tag, " R9 no early write"}, 64'(rt_we), 64'd0);
    mem_rsp_valid = 1'b1; mem_rsp_data = mem;
    @(posedge clk);
    @(negedge clk);
    mem_rsp_valid = 1'b0; mem_rsp_data = '0;
    check(rt_we && ra_we, {tag, " R9 both enables"}, {62'd0, rt_we, ra_we}, 64'd3);
    check(rt_wnum == rt && ra_wnum == ra, {tag, " R9 register numbers"},
          {54'd0, rt_wnum, ra_wnum}, {54'd0, rt, ra});
    check(rt_wdata == ref_load(sz, sg, b, mem), {tag, " target value"},
          rt_wdata, ref_load(sz, sg, b, mem));
    check(ra_wdata == ref_base(sz, ix, b, x, d), {tag, " updated base"},
          ra_wdata, ref_base(sz, ix, b, x, d));
    check(busy == 1'b1, {tag, " R10 busy in writeback"}, 64'(busy), 64'd1);
    @(posedge clk);
    @(negedge clk);
    check(!rt_we && !ra_we && !busy && op_ready, {tag, " R10 idle after writeback"},
          {61'd0, rt_we, ra_we, busy}, 64'd0);
  endtask

  task automatic run_invalid(input string tag, input logic [4:0] rt, input logic [4:0] ra);
    @(negedge clk);
    mem_req_ready = 1'b1;
    op_valid = 1'b1; op_size = 2'd2; op_indexed = 1'b0; base_val = 64'h1000;
    rt_num = rt; ra_num = ra;
    @(posedge clk);
    @(negedge clk);
    op_valid = 1'b0;
    check(form_invalid == 1'b1, {tag, " R8 flag"}, 64'(form_invalid), 64'd1);
    check(!mem_req_valid && !busy && !rt_we && !ra_we, {tag, " R8 quiet"},
          {60'd0, mem_req_valid, busy, rt_we, ra_we}, 64'd0);
    @(posedge clk);
    @(negedge clk);
    mem_req_ready = 1'b0;
    check(!form_invalid && !busy && !mem_req_valid, {tag, " R8 one cycle"},
          {61'd0, form_invalid, busy, mem_req_valid}, 64'd0);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(op_ready && !busy && !mem_req_valid && !rt_we && !ra_we && !form_invalid,
          "R10 reset state", {58'd0, op_ready, busy, mem_req_valid, rt_we, ra_we,
          form_invalid}, 64'h20);
  endtask

  task automatic t_zero_ext();
    run_op("R5 byte lane5", 2'd0, 1'b0, 1'b0, 64'h2005, '0, 16'h0010, 5'd3, 5'd4, PAT, 0);
    run_op("R5 half lane7", 2'd1, 1'b0, 1'b0, 64'h3007, '0, 16'h0002, 5'd6, 5'd7, PAT, 0);
    run_op("R5 word lane6", 2'd2, 1'b0, 1'b0, 64'h4006, '0, 16'h0100, 5'd8, 5'd9, PAT, 0);
  endtask

  task automatic t_sign_ext();
    run_op("R6 half alg", 2'd1, 1'b1, 1'b0, 64'h5006, '0, 16'hFFFE, 5'd1, 5'd2, PAT, 0);
    run_op("R6 word alg", 2'd2, 1'b1, 1'b0, 64'h6004, '0, 16'h8000, 5'd10, 5'd11, PAT, 0);
    run_op("R6 byte ignores", 2'd0, 1'b1, 1'b0, 64'h7004, '0, 16'h0001, 5'd12, 5'd13, PAT, 0);
  endtask

  task automatic t_dword();
    run_op("R7 R3 dword imm", 2'd3, 1'b0, 1'b0, 64'h8000, '0, 16'hFFF7, 5'd14, 5'd15,
           64'hFEDC_BA98_7654_3210, 0);
    run_op("R2 R3 dword pos", 2'd3, 1'b1, 1'b0, 64'h9008, '0, 16'h0013, 5'd16, 5'd17,
           64'h8000_0000_0000_0001, 0);
  endtask

  task automatic t_indexed();
    run_op("R4 indexed", 2'd2, 1'b0, 1'b1, 64'hA000, 64'hFFFF_FFFF_FFFF_FF00,
           16'h1234, 5'd18, 5'd19, PAT, 0);
  endtask

  task automatic t_stall();
    run_op("R1 stall", 2'd1, 1'b0, 1'b0, 64'hB002, '0, 16'h0020, 5'd20, 5'd21, PAT, 4);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%h expected=%h", 64'd0, 64'd1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_zero_ext();
    t_sign_ext();
    t_dword();
    t_indexed();
    t_stall();
    run_invalid("R8 ra zero", 5'd5, 5'd0);
    run_invalid("R8 ra eq rt", 5'd9, 5'd9);
    run_op("R9 after invalid", 2'd0, 1'b0, 1'b0, 64'hC007, '0, 16'hFFFF, 5'd22, 5'd23, PAT, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule